// File: doc/BRIEF.md
# Dual Wiper Register Controller

This block is the command-level core of a two-channel, 256-position digital potentiometer. A bus front end hands it one decoded command at a time: a target device address, an opcode, a channel select, a 2-bit stored-register index and a data byte. The block keeps one 8-bit wiper register per channel and eight 8-bit stored registers, four per channel. It turns each wiper value into a one-hot 256-line tap-select bus that drives the resistor array.

Commands can read or write a wiper or a stored register. They can copy a stored register into its channel's wiper, or save a wiper into one of its channel's stored registers. They can also step a wiper up or down by one position. Stored registers model non-volatile cells. A write to one holds the block busy for a fixed number of cycles, and an active-low write-protect input can refuse such writes without affecting the wipers.

Top module: `dualWiperCtrl`

## Requirements
- R1: A command is accepted only when `cmdValid` is high, `cmdAddr` equals `devAddrPins` and `busy` is low. A command that is not accepted changes no register, produces no read response and raises no error.
- R2: Opcode 2 writes `cmdData` into the wiper of channel `cmdChan`. Opcode 1 reads that wiper: `rdValid` is high, and `rdData` holds the value, in the cycle after the accepting edge.
- R3: Each tap-select bus is one-hot, with only bit N set, where N is the current wiper value of its channel. The bus follows the wiper in the same cycle.
- R4: Opcode 4 writes `cmdData` into stored register `cmdChan*4 + cmdIdx`. Opcode 3 reads that register back, with the same timing as R2.
- R5: While `wpN` is low, opcode 4 and opcode 6 are refused: no stored register changes and `busy` stays low. `wpErr` is then high for exactly the one cycle after the refusing edge. Wiper writes are still accepted.
- R6: Opcode 5 copies stored register `cmdChan*4 + cmdIdx` into the wiper of channel `cmdChan`.
- R7: Opcode 6 copies the wiper of channel `cmdChan` into stored register `cmdChan*4 + cmdIdx`.
- R8: Opcode 7 steps the wiper of channel `cmdChan` by one position. It steps up when `cmdData[0]` is 1 and down when it is 0. A step up holds at 255 and a step down holds at 0.
- R9: An accepted stored-register write (opcode 4) or an accepted save (opcode 6) holds `busy` high for `BUSY_CYCLES` cycles (default 8), starting in the cycle after the accepting edge. Commands arriving during that time are ignored.
- R10: After reset, every stored register holds `INIT_VAL` (default 0x80). Each wiper equals its channel's stored register 0. `busy`, `wpErr` and `rdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| devAddrPins | input | 4 | Strapped device address |
| wpN | input | 1 | Write protect for stored registers, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdAddr | input | 4 | Target device address of the command |
| cmdOp | input | 3 | Opcode (0 none, 1 read wiper, 2 write wiper, 3 read stored, 4 write stored, 5 load wiper, 6 save wiper, 7 step) |
| cmdChan | input | 1 | Channel select |
| cmdIdx | input | 2 | Stored-register index within the channel |
| cmdData | input | 8 | Write data; bit 0 gives the step direction |
| rdValid | output | 1 | Read response valid |
| rdData | output | 8 | Read response data |
| busy | output | 1 | Stored-register write in progress |
| wpErr | output | 1 | Protected write refused (one-cycle pulse) |
| tapSel0 | output | 256 | One-hot tap select, channel 0 |
| tapSel1 | output | 256 | One-hot tap select, channel 1 |

## Verification
Every command is driven on a falling edge and is accepted on the next rising edge. Wiper, stored-register and tap-select results are therefore due at the falling edge that follows, and so are `rdValid`, `rdData` and the one-cycle `wpErr` pulse. The bench samples all of them at that falling edge, one half-period after the register update.

`busy` is counted falling edge by falling edge from that same point and must read exactly `BUSY_CYCLES`. Before each new command, the bench waits for `busy` to drop, except in the test that probes refusal during busy.

// File: rtl/potPkg.sv
package potPkg;
  localparam int WIPER_W       = 8;
  localparam int TAPS          = 1 << WIPER_W;
  localparam int NUM_CHAN      = 2;
  localparam int REGS_PER_CHAN = 4;
  localparam int IDX_W         = $clog2(REGS_PER_CHAN);
  localparam int NUM_REGS      = NUM_CHAN * REGS_PER_CHAN;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_RD_WIPER = 3'd1,
    OP_WR_WIPER = 3'd2,
    OP_RD_STORE = 3'd3,
    OP_WR_STORE = 3'd4,
    OP_LOAD     = 3'd5,
    OP_SAVE     = 3'd6,
    OP_STEP     = 3'd7
  } potOp_e;

  typedef struct packed {
    logic               rdWiper;
    logic               wrWiper;
    logic               rdStore;
    logic               wrStore;
    logic               loadWiper;
    logic               saveWiper;
    logic               stepEn;
    logic               stepUp;
    logic               chan;
    logic [IDX_W-1:0]   idx;
    logic [WIPER_W-1:0] data;
  } potStrobe_t;
endpackage

// File: rtl/potCtrl.sv
module potCtrl
  import potPkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         devAddrPins,
  input  logic               wpN,
  input  logic               cmdValid,
  input  logic [3:0]         cmdAddr,
  input  logic [2:0]         cmdOp,
  input  logic               cmdChan,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic [WIPER_W-1:0] cmdData,
  output potStrobe_t         strobe,
  output logic               busy,
  output logic               wpErr
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             accept;
  logic             guardedOp;
  logic             storeGo;
  potOp_e           op;

  assign op        = potOp_e'(cmdOp);
  assign busy      = (busyCnt != '0);
  assign accept    = cmdValid && (cmdAddr == devAddrPins) && !busy;
  assign guardedOp = accept && (op == OP_WR_STORE || op == OP_SAVE);
  assign storeGo   = guardedOp && wpN;

  always_comb begin
    strobe      = '0;
    strobe.chan = cmdChan;
    strobe.idx  = cmdIdx;
    strobe.data = cmdData;
    if (accept) begin
      unique case (op)
        OP_RD_WIPER: strobe.rdWiper   = 1'b1;
        OP_WR_WIPER: strobe.wrWiper   = 1'b1;
        OP_RD_STORE: strobe.rdStore   = 1'b1;
        OP_WR_STORE: strobe.wrStore   = wpN;
        OP_LOAD:     strobe.loadWiper = 1'b1;
        OP_SAVE:     strobe.saveWiper = wpN;
        OP_STEP: begin
          strobe.stepEn = 1'b1;
          strobe.stepUp = cmdData[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      wpErr   <= 1'b0;
    end else begin
      wpErr <= guardedOp && !wpN;
      if (storeGo)       busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busy)     busyCnt <= busyCnt - 1'b1;
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid && wpN));

  // R5
  wp_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    wpErr |-> ($past(!wpN) && !busy));
endmodule

// File: rtl/potDatapath.sv
module potDatapath
  import potPkg::*;
#(
  parameter logic [WIPER_W-1:0] INIT_VAL = 8'h80
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wpN,
  input  potStrobe_t                     strobe,
  output logic                           rdValid,
  output logic [WIPER_W-1:0]             rdData,
  output logic [NUM_CHAN-1:0][TAPS-1:0]  tapBus
);
  localparam logic [WIPER_W-1:0] STEP1 = 1;
  localparam logic [WIPER_W-1:0] MAXV  = '1;
  localparam logic [WIPER_W-1:0] MINV  = '0;

  logic [WIPER_W-1:0] wiperQ [NUM_CHAN];
  logic [WIPER_W-1:0] storeQ [NUM_REGS];
  logic [$clog2(NUM_REGS)-1:0] regSel;
  logic [WIPER_W-1:0] curWiper;

  assign regSel   = {strobe.chan, strobe.idx};
  assign curWiper = wiperQ[strobe.chan];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) storeQ[r] <= INIT_VAL;
      for (int c = 0; c < NUM_CHAN; c++) wiperQ[c] <= INIT_VAL;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.wrWiper)   wiperQ[strobe.chan] <= strobe.data;
      if (strobe.loadWiper) wiperQ[strobe.chan] <= storeQ[regSel];
      if (strobe.stepEn) begin
        if (strobe.stepUp && curWiper != MAXV)
          wiperQ[strobe.chan] <= curWiper + STEP1;
        else if (!strobe.stepUp && curWiper != MINV)
          wiperQ[strobe.chan] <= curWiper - STEP1;
      end
      if (strobe.wrStore)   storeQ[regSel] <= strobe.data;
      if (strobe.saveWiper) storeQ[regSel] <= curWiper;
      rdValid <= strobe.rdWiper || strobe.rdStore;
      if (strobe.rdWiper)      rdData <= curWiper;
      else if (strobe.rdStore) rdData <= storeQ[regSel];
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    assign tapBus[c] = {{(TAPS-1){1'b0}}, 1'b1} << wiperQ[c];

    // R3
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $countones(tapBus[c]) == 1);

    // R8
    step_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.stepEn && strobe.stepUp && strobe.chan == c && wiperQ[c] == MAXV)
        |=> (wiperQ[c] == MAXV));

    // R8
    step_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.stepEn && !strobe.stepUp && strobe.chan == c && wiperQ[c] == MINV)
        |=> (wiperQ[c] == MINV));
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_store
    // R5
    store_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(storeQ[r]) |-> $past(wpN));
  end
endmodule

// File: rtl/dualWiperCtrl.sv
module dualWiperCtrl
  import potPkg::*;
#(
  parameter int                 BUSY_CYCLES = 8,
  parameter logic [WIPER_W-1:0] INIT_VAL    = 8'h80
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    devAddrPins,
  input  logic          wpN,
  input  logic          cmdValid,
  input  logic [3:0]    cmdAddr,
  input  logic [2:0]    cmdOp,
  input  logic          cmdChan,
  input  logic [1:0]    cmdIdx,
  input  logic [7:0]    cmdData,
  output logic          rdValid,
  output logic [7:0]    rdData,
  output logic          busy,
  output logic          wpErr,
  output logic [255:0]  tapSel0,
  output logic [255:0]  tapSel1
);
  potStrobe_t                    strobe;
  logic [NUM_CHAN-1:0][TAPS-1:0] tapBus;

  potCtrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .devAddrPins(devAddrPins), .wpN(wpN),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdOp(cmdOp), .cmdChan(cmdChan),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .strobe(strobe), .busy(busy), .wpErr(wpErr)
  );

  potDatapath #(.INIT_VAL(INIT_VAL)) dp_i (
    .clk(clk), .rstN(rstN), .wpN(wpN), .strobe(strobe),
    .rdValid(rdValid), .rdData(rdData), .tapBus(tapBus)
  );

  assign tapSel0 = tapBus[0];
  assign tapSel1 = tapBus[1];

  // R1
  no_resp_without_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(cmdValid && cmdAddr == devAddrPins));
endmodule

// File: tb/dualWiperCtrl_tb_top.sv
module dualWiperCtrl_tb_top;
  localparam int BUSY = 8;
  localparam logic [3:0] MYADDR = 4'hA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] devAddrPins = MYADDR;
  logic wpN = 1'b1;
  logic cmdValid = 1'b0;
  logic [3:0] cmdAddr = '0;
  logic [2:0] cmdOp = '0;
  logic cmdChan = 1'b0;
  logic [1:0] cmdIdx = '0;
  logic [7:0] cmdData = '0;
  logic rdValid, busy, wpErr;
  logic [7:0] rdData;
  logic [255:0] tapSel0, tapSel1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dualWiperCtrl dut_i (
    .clk(clk), .rstN(rstN), .devAddrPins(devAddrPins), .wpN(wpN),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdOp(cmdOp), .cmdChan(cmdChan),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .rdValid(rdValid), .rdData(rdData),
    .busy(busy), .wpErr(wpErr), .tapSel0(tapSel0), .tapSel1(tapSel1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkTap(input string req, input logic ch, input logic [7:0] pos);
    logic [255:0] act;
    logic [255:0] exp;
    act = ch ? tapSel1 : tapSel0;
    exp = 256'd1 << pos;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s tap ch%0d actual=%h expected=%h", req, ch, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic ch, input logic [1:0] idx,
                      input logic [7:0] data, input logic [3:0] addr);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdChan = ch; cmdIdx = idx; cmdData = data; cmdAddr = addr;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic readBack(input string req, input logic [2:0] op, input logic ch,
                          input logic [1:0] idx, input logic [7:0] exp);
    send(op, ch, idx, 8'h00, MYADDR);
    chk(req, int'(rdValid), 1);
    chk(req, int'(rdData), int'(exp));
  endtask

  task automatic tReset();
    chk("R10 busy", int'(busy), 0);
    chk("R10 wpErr", int'(wpErr), 0);
    chk("R10 rdValid", int'(rdValid), 0);
    chkTap("R10", 1'b0, 8'h80);
    chkTap("R10", 1'b1, 8'h80);
    readBack("R10 store0", 3'd3, 1'b1, 2'd0, 8'h80);
    readBack("R10 wiper", 3'd1, 1'b1, 2'd0, 8'h80);
  endtask

  task automatic tAddr();
    send(3'd2, 1'b0, 2'd0, 8'h11, 4'h5);
    chkTap("R1 mismatch write", 1'b0, 8'h80);
    send(3'd1, 1'b0, 2'd0, 8'h00, 4'h5);
    chk("R1 mismatch read", int'(rdValid), 0);
  endtask

  task automatic tWiper();
    send(3'd2, 1'b0, 2'd0, 8'h3C, MYADDR);
    chkTap("R3 ch0", 1'b0, 8'h3C);
    chkTap("R3 ch1 untouched", 1'b1, 8'h80);
    readBack("R2 rd ch0", 3'd1, 1'b0, 2'd0, 8'h3C);
    send(3'd2, 1'b1, 2'd0, 8'h00, MYADDR);
    chkTap("R3 pos0", 1'b1, 8'h00);
    readBack("R2 rd ch1", 3'd1, 1'b1, 2'd0, 8'h00);
  endtask

  task automatic tStore();
    send(3'd4, 1'b1, 2'd3, 8'hC5, MYADDR);
    waitIdle();
    send(3'd4, 1'b0, 2'd3, 8'h21, MYADDR);
    waitIdle();
    readBack("R4 ch1 idx3", 3'd3, 1'b1, 2'd3, 8'hC5);
    readBack("R4 ch0 idx3", 3'd3, 1'b0, 2'd3, 8'h21);
  endtask

  task automatic tLoadSave();
    send(3'd5, 1'b0, 2'd3, 8'h00, MYADDR);
    chkTap("R6 load", 1'b0, 8'h21);
    send(3'd2, 1'b1, 2'd0, 8'h5A, MYADDR);
    send(3'd6, 1'b1, 2'd2, 8'h00, MYADDR);
    waitIdle();
    readBack("R7 save", 3'd3, 1'b1, 2'd2, 8'h5A);
  endtask

  task automatic tProtect();
    wpN = 1'b0;
    send(3'd4, 1'b0, 2'd1, 8'h33, MYADDR);
    chk("R5 err pulse", int'(wpErr), 1);
    chk("R5 no busy", int'(busy), 0);
    readBack("R5 store kept", 3'd3, 1'b0, 2'd1, 8'h80);
    chk("R5 err cleared", int'(wpErr), 0);
    send(3'd6, 1'b1, 2'd3, 8'h00, MYADDR);
    chk("R5 save err", int'(wpErr), 1);
    readBack("R5 save kept", 3'd3, 1'b1, 2'd3, 8'hC5);
    send(3'd2, 1'b0, 2'd0, 8'h77, MYADDR);
    chkTap("R5 wiper allowed", 1'b0, 8'h77);
    wpN = 1'b1;
  endtask

  task automatic tStep();
    send(3'd2, 1'b1, 2'd0, 8'hFE, MYADDR);
    send(3'd7, 1'b1, 2'd0, 8'h01, MYADDR);
    chkTap("R8 up", 1'b1, 8'hFF);
    send(3'd7, 1'b1, 2'd0, 8'h01, MYADDR);
    chkTap("R8 ceiling", 1'b1, 8'hFF);
    send(3'd2, 1'b1, 2'd0, 8'h01, MYADDR);
    send(3'd7, 1'b1, 2'd0, 8'h00, MYADDR);
    chkTap("R8 down", 1'b1, 8'h00);
    send(3'd7, 1'b1, 2'd0, 8'h00, MYADDR);
    chkTap("R8 floor", 1'b1, 8'h00);
  endtask

  task automatic tBusy();
    int n;
    send(3'd4, 1'b0, 2'd2, 8'h44, MYADDR);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk("R9 busy length", n, BUSY);
    send(3'd4, 1'b0, 2'd2, 8'h45, MYADDR);
    send(3'd2, 1'b0, 2'd0, 8'h12, MYADDR);
    chkTap("R9 refused while busy", 1'b0, 8'h77);
    waitIdle();
    readBack("R9 store done", 3'd3, 1'b0, 2'd2, 8'h45);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAddr();
    tWiper();
    tStore();
    tLoadSave();
    tProtect();
    tStep();
    tBusy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule